// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block controls when a successive-approximation converter front end samples, converts and hands over its result. An active-low start input begins a conversion on its falling edge. During the conversion the block drives a hold control and a busy flag. At the end it pulses a strobe for one cycle and copies the result word into the output register. Busy then drops, and its falling edge tells a reader that fresh data is ready. The comparator and DAC are not modelled. A result word supplied at the input stands in for them, and two counters set the fixed conversion and acquisition lengths.

Acquisition starts as soon as busy falls and lasts a fixed number of cycles. A conversion cannot begin until acquisition has ended. In normal mode, a start edge that arrives during acquisition is ignored. In impulse mode, a start that is still held low when acquisition ends fires at once, with no idle cycle. A high power-down input blocks new conversions but lets a running conversion finish. A synchronous reset aborts any conversion and returns the block to acquisition.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, hold, busy and latch_stb are 0 and data_out is all zeros. A reset raised during a conversion ends it with no latch_stb pulse.
- R2: In the ready state, a falling edge on start_n (sampled 1 on one rising clock edge and 0 on the next) with pwr_down low raises hold and busy one cycle after the edge is sampled.
- R3: hold stays high for exactly CONV_CYC consecutive cycles per conversion.
- R4: latch_stb is high for exactly one cycle, the cycle right after hold falls. The value of result_in in that cycle appears on data_out in the next cycle.
- R5: busy is high during the hold cycles and the strobe cycle, which is CONV_CYC+1 cycles in all, and it falls in the cycle after latch_stb.
- R6: Acquisition lasts ACQ_CYC cycles counted from the first cycle with busy low. In normal mode (impulse_mode=0), a start edge sampled during acquisition does not start a conversion, even if start_n then stays low.
- R7: A start edge sampled while busy is high has no effect. In normal mode, busy stays low after that conversion ends.
- R8: In impulse mode (impulse_mode=1), if start_n is low on the last acquisition cycle, hold rises on the very next cycle. An edge that arrives after acquisition behaves as in R2.
- R9: While pwr_down is high, no conversion starts, whether from a start edge or from the impulse rule.
- R10: Raising pwr_down during a conversion does not shorten it. The strobe and the data transfer still happen.
- R11: data_out changes only in the cycle after a latch_stb pulse or after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; aborts any conversion |
| start_n | input | 1 | Active-low start request; the falling edge starts a conversion |
| pwr_down | input | 1 | High blocks new conversions |
| impulse_mode | input | 1 | 1 = impulse mode, 0 = normal mode |
| result_in | input | DATA_W | Stub result word from the conversion datapath |
| hold | output | 1 | Sample/hold control, high while converting |
| busy | output | 1 | High from conversion start until the result is latched |
| latch_stb | output | 1 | One-cycle strobe when the result is transferred |
| data_out | output | DATA_W | Latched conversion result |

## Verification
The assertions assume the following about the inputs:
- start_n, pwr_down and impulse_mode are already synchronous to clk.
- impulse_mode changes only while reset is high.
- Reset is held for at least two cycles.

The bench respects all three. It drives every input on the falling clock edge and holds reset for three cycles. It changes the mode only inside a reset. Each sweep point starts either from a fresh reset or from the end of a conversion. The start request is placed at every offset in and after the acquisition window, in both modes and with power-down both high and low.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Controller phases; hold/busy/strobe are decoded from these.
    typedef enum logic [1:0] {
        PH_ACQ   = 2'd0,
        PH_READY = 2'd1,
        PH_CONV  = 2'd2,
        PH_XFER  = 2'd3
    } sar_phase_e;

    typedef struct packed {
        logic hold;
        logic busy;
        logic latch;
    } sar_ctl_t;

    // Counter width that covers the longer of the two phases.
    function automatic int cnt_width(input int conv_len, input int acq_len);
        int longest;
        longest = (conv_len > acq_len) ? conv_len : acq_len;
        return $clog2(longest + 1);
    endfunction

    function automatic sar_ctl_t decode_phase(input sar_phase_e ph);
        sar_ctl_t c;
        c.hold  = (ph == PH_CONV);
        c.busy  = (ph == PH_CONV) || (ph == PH_XFER);
        c.latch = (ph == PH_XFER);
        return c;
    endfunction

endpackage

// File: rtl/sar_start_edge.sv
module sar_start_edge (
    input  logic clk,
    input  logic rst,
    input  logic start_n,
    output logic fall,
    output logic start_low
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= start_n;
    end

    assign fall      = prev_q & ~start_n;
    assign start_low = ~start_n;

endmodule

// File: rtl/sar_phase_cnt.sv
module sar_phase_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (en)    cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == limit);

    // R3: a running count never passes the terminal value of its phase
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q <= limit));

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int CONV_CYC = 20,
    parameter int ACQ_CYC  = 6
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fall,
    input  logic     start_low,
    input  logic     pwr_down,
    input  logic     impulse_mode,
    output sar_ctl_t ctl
);
    localparam int CW = cnt_width(CONV_CYC, ACQ_CYC);
    localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);
    localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_CYC - 1);

    sar_phase_e    phase_q, phase_d;
    logic [CW-1:0] limit;
    logic          last, cnt_clr, cnt_en, may_start;

    assign may_start = ~pwr_down;
    assign limit     = (phase_q == PH_CONV) ? CONV_LAST : ACQ_LAST;
    assign cnt_en    = (phase_q == PH_ACQ) || (phase_q == PH_CONV);
    assign cnt_clr   = (phase_d != phase_q);

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_ACQ: begin
                if (last) begin
                    if (impulse_mode && start_low && may_start) phase_d = PH_CONV;
                    else                                        phase_d = PH_READY;
                end
            end
            PH_READY: if (fall && may_start) phase_d = PH_CONV;
            PH_CONV:  if (last) phase_d = PH_XFER;
            PH_XFER:  phase_d = PH_ACQ;
            default:  phase_d = PH_ACQ;
        endcase
    end

    sar_phase_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .limit (limit),
        .last  (last)
    );

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_ACQ;
        else     phase_q <= phase_d;
    end

    assign ctl = decode_phase(phase_q);

    // R9: a conversion never begins on a cycle where power-down was high
    p_pd_blocks_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.hold) |-> !$past(pwr_down));

    // R6: in normal mode the acquisition phase never leads straight to hold
    p_acq_no_direct_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACQ && !impulse_mode) |=> !ctl.hold);

    // R8: impulse mode fires at the end of acquisition if start is held
    p_impulse_fire_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACQ && last && impulse_mode && start_low && !pwr_down) |=> ctl.hold);

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CONV_CYC = 20,
    parameter int ACQ_CYC  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_n,
    input  logic              pwr_down,
    input  logic              impulse_mode,
    input  logic [DATA_W-1:0] result_in,
    output logic              hold,
    output logic              busy,
    output logic              latch_stb,
    output logic [DATA_W-1:0] data_out
);
    logic              fall, start_low;
    sar_ctl_t          ctl;
    logic [DATA_W-1:0] data_q;

    sar_start_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .start_n   (start_n),
        .fall      (fall),
        .start_low (start_low)
    );

    sar_seq_fsm #(
        .CONV_CYC (CONV_CYC),
        .ACQ_CYC  (ACQ_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .fall         (fall),
        .start_low    (start_low),
        .pwr_down     (pwr_down),
        .impulse_mode (impulse_mode),
        .ctl          (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst)            data_q <= '0;
        else if (ctl.latch) data_q <= result_in;
    end

    assign hold      = ctl.hold;
    assign busy      = ctl.busy;
    assign latch_stb = ctl.latch;
    assign data_out  = data_q;

    // R4: the strobe follows the fall of hold directly
    p_latch_after_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> latch_stb);

    // R5: busy drops the cycle after the strobe
    p_busy_falls_r5: assert property (@(posedge clk) disable iff (rst)
        latch_stb |=> !busy);

    // R2: hold is only ever asserted inside a busy window
    p_hold_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
        hold |-> busy);

    // R7: busy cannot end except through the strobe
    p_busy_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !latch_stb) |=> busy);

    // R11: output word only moves after a strobe
    p_data_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(latch_stb) && !$past(rst)) |-> $stable(data_out));

endmodule

// File: tb/sar_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sar_seq_ctrl_bench;
    localparam int DW   = 8;
    localparam int CONV = 4;
    localparam int ACQ  = 3;
    localparam int HOR  = ACQ + 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_n = 1'b1;
    logic          pwr_down = 1'b0;
    logic          impulse_mode = 1'b0;
    logic [DW-1:0] result_in = '0;
    logic          hold, busy, latch_stb;
    logic [DW-1:0] data_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sar_seq_ctrl #(.DATA_W(DW), .CONV_CYC(CONV), .ACQ_CYC(ACQ)) u_sar_seq_ctrl (
        .clk(clk), .rst(rst), .start_n(start_n), .pwr_down(pwr_down),
        .impulse_mode(impulse_mode), .result_in(result_in), .hold(hold),
        .busy(busy), .latch_stb(latch_stb), .data_out(data_out)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; returns at the negedge where reset is released (t=0).
    task automatic do_reset(input logic mode);
        rst = 1'b1; start_n = 1'b1; pwr_down = 1'b0; impulse_mode = mode;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 hold in reset", hold, 0);
        chk("R1 strobe in reset", latch_stb, 0);
        chk("R1 data in reset", data_out, 0);
        rst = 1'b0;
    endtask

    // Starts at the negedge where hold should first be high; ends at the
    // negedge where busy is first low again.
    task automatic check_conv(input logic [DW-1:0] exp_data, input bit pd_mid, input bit edge_mid);
        for (int i = 0; i < CONV; i++) begin
            chk("R2/R3 hold high", hold, 1);
            chk("R5 busy high", busy, 1);
            chk("R4 no early strobe", latch_stb, 0);
            if (i == 1) start_n = 1'b1;
            if (i == 1 && pd_mid) pwr_down = 1'b1;
            if (i == 2 && edge_mid) start_n = 1'b0;
            @(negedge clk);
        end
        chk("R3 hold dropped", hold, 0);
        chk("R4 strobe", latch_stb, 1);
        chk("R5 busy through strobe", busy, 1);
        @(negedge clk);
        chk("R5 busy fell", busy, 0);
        chk("R4 strobe single", latch_stb, 0);
        chk("R4 data latched", data_out, exp_data);
    endtask

    task automatic run_trial(input logic mode, input int t, input bit pd, input bit from_conv);
        int s;
        bit done;
        logic [DW-1:0] res;
        res = DW'(8'hA5 ^ (t * 17) ^ int'(mode) ^ (from_conv ? 8'h3C : 8'h00));
        result_in = res;
        do_reset(mode);
        if (from_conv) begin
            repeat (ACQ) @(negedge clk);
            start_n = 1'b0;
            @(negedge clk);
            check_conv(res, 1'b0, 1'b0);
            res = ~res;
            result_in = res;
        end
        pwr_down = pd;
        if (pd)             s = -1;
        else if (mode == 0) s = (t >= ACQ) ? t + 1 : -1;
        else                s = (t + 1 > ACQ) ? t + 1 : ACQ;
        done = 0;
        for (int n = 0; n <= HOR; n++) begin
            if (n == s) begin
                check_conv(res, 1'b0, 1'b0);
                done = 1;
                break;
            end
            if (pd)        chk("R9 no start under power-down", busy, 0);
            else if (mode) chk("R8 no premature start", busy, 0);
            else           chk("R6 idle during acquisition", busy, 0);
            if (n == t) start_n = 1'b0;
            @(negedge clk);
        end
        if (s >= 0 && !done) chk("R8 start missed", 0, 1);
        start_n = 1'b1;
        pwr_down = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] kept;
        @(negedge clk);
        do_reset(1'b0);
        chk("R1 data after reset", data_out, 0);
        chk("R1 busy after reset", busy, 0);

        // Sweep start offset over both modes, power-down on/off, from reset.
        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 2; p++)
                for (int t = 0; t <= ACQ + 2; t++)
                    run_trial(m[0], t, p[0], 1'b0);
        // Same offsets measured from the fall of busy after a conversion.
        for (int m = 0; m < 2; m++)
            for (int t = 0; t <= ACQ + 2; t++)
                run_trial(m[0], t, 1'b0, 1'b1);

        // R7: edge during conversion ignored in normal mode.
        result_in = 8'h5A;
        do_reset(1'b0);
        repeat (ACQ) @(negedge clk);
        start_n = 1'b0;
        @(negedge clk);
        check_conv(8'h5A, 1'b0, 1'b1);
        for (int k = 0; k < ACQ + 4; k++) begin
            chk("R7 edge while busy ignored", busy, 0);
            @(negedge clk);
        end
        start_n = 1'b1;
        @(negedge clk);

        // R10: power-down raised mid-conversion; then R9 blocks, R2 resumes.
        result_in = 8'hC3;
        do_reset(1'b0);
        repeat (ACQ) @(negedge clk);
        start_n = 1'b0;
        @(negedge clk);
        check_conv(8'hC3, 1'b1, 1'b0);
        chk("R10 conversion completed", data_out, 8'hC3);
        repeat (ACQ + 1) @(negedge clk);
        start_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R9 edge blocked by power-down", busy, 0);
        end
        pwr_down = 1'b0;
        start_n = 1'b1;
        @(negedge clk);
        result_in = 8'h96;
        start_n = 1'b0;
        @(negedge clk);
        check_conv(8'h96, 1'b0, 1'b0);
        start_n = 1'b1;

        // R11: data_out holds while result_in moves.
        kept = data_out;
        for (int k = 0; k < 4; k++) begin
            result_in = DW'(k * 37 + 1);
            @(negedge clk);
            chk("R11 data held", data_out, kept);
        end

        // R1: reset aborts a conversion without a strobe.
        result_in = 8'h77;
        do_reset(1'b0);
        repeat (ACQ) @(negedge clk);
        start_n = 1'b0;
        @(negedge clk);
        chk("R2 hold before abort", hold, 1);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 abort busy", busy, 0);
        chk("R1 abort hold", hold, 0);
        chk("R1 abort no strobe", latch_stb, 0);
        chk("R1 abort data", data_out, 0);
        start_n = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < CONV + 2; k++) begin
            chk("R1 no strobe after abort", latch_stb, 0);
            @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule